// File: doc/BRIEF.md
# Link Word Transmitter

This block sends whole data words over a narrow point-to-point link. Words of 48 or 32 bits are written into a two-entry transmit queue. Each word is then cut into bytes, or into nibbles, and sent most significant part first. A strobe line rises as each new part is put on the data lines. The far end latches the part when the strobe falls.

The receiver paces the link with an acknowledge line. That line is looked at only when a word is about to start. If it is low at that moment, the transmitter puts out the first part of the next word, holds the strobe high and waits. If the queue is empty, the strobe stays low whatever the acknowledge line does. The strobe period is derived from the core clock by a divisor of 1 to 4.

Word size, lane width and divisor are captured when the block is enabled. Dropping the enable empties the queue.

Top module: `strobe_link_tx`

## Requirements
- R1: With `byte_lane`=1 a word is sent as 4 parts (`wide_word`=0) or 6 parts (`wide_word`=1) of 8 bits on `lnk_data[7:0]`. With `byte_lane`=0 it is sent as 8 or 12 nibbles on `lnk_data[3:0]`, and `lnk_data[7:4]` is 0.
- R2: The most significant part is sent first. A 32-bit word is taken from `wr_data[31:0]`.
- R3: Each part is presented with `lnk_clk` high for N core cycles and then `lnk_clk` low for N core cycles. The data stays constant across both phases. N is 1, 2, 3 or 4 for `clk_div` codes 01, 10, 11 and 00.
- R4: `ack_in` is sampled only when a word starts. A word that has started is always sent in full, even if `ack_in` falls part way through.
- R5: If `ack_in` is low when a queued word would start, `lnk_clk` is held high and the word's first part stays on `lnk_data`. In the cycle after `ack_in` is seen high, `lnk_clk` falls; it stays low for N cycles and the word then continues.
- R6: While the queue is empty, `lnk_clk` is 0 and `lnk_data` is 0, whatever the level of `ack_in`.
- R7: The queue holds two words. `fifo_status` reads 00 when empty, 10 with one word and 11 with two words. A word stays counted until the low phase of its last part ends. `wr_ready` is low when the queue is full or the block is disabled.
- R8: A write presented while `wr_ready` is low is dropped, and `overflow` is high for exactly the following cycle. Any other cycle leaves `overflow` low in the cycle after it.
- R9: Only the words accepted are sent, each once, in the order they were written.
- R10: While `enable` is low, the next cycle shows the queue cleared (`fifo_status`=00) and `lnk_clk` low. Words that were discarded this way are never sent.
- R11: `wide_word`, `byte_lane` and `clk_div` are captured on the cycle in which `enable` rises. Changing them while enabled has no effect until the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low clears the queue |
| wide_word | input | 1 | 1 = 48-bit words, 0 = 32-bit words |
| byte_lane | input | 1 | 1 = 8-bit lane, 0 = 4-bit lane |
| clk_div | input | 2 | Strobe divisor code (01=1, 10=2, 11=3, 00=4) |
| wr_valid | input | 1 | Write strobe for one word |
| wr_data | input | 48 | Word to queue |
| wr_ready | output | 1 | Queue can accept a word |
| overflow | output | 1 | One-cycle pulse after a dropped write |
| ack_in | input | 1 | Receiver acknowledge |
| lnk_data | output | 8 | Link data lines |
| lnk_clk | output | 1 | Link strobe |
| fifo_status | output | 2 | Queue fill: 00 empty, 10 one, 11 full |

## Verification
The bench builds the block with its default parameters: a 48-bit long word, a 32-bit short word, an 8-bit lane and a two-entry queue. Those values bring every part count within reach, from 4 bytes up to 12 nibbles. They also let the queue reach full, so a third write can be refused and the overflow pulse observed. With a 48-bit word and a divisor of 2, the bench can lower acknowledge in the middle of a word and still catch the next word stalled at its first byte. All four divisor codes are measured directly as strobe high and low times.

// File: rtl/strobe_link_pkg.sv
package strobe_link_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_HIGH  = 2'd1,
        TX_LOW   = 2'd2,
        TX_STALL = 2'd3
    } tx_state_e;

    // Divisor code to core cycles per strobe phase: 00 means four.
    function automatic logic [2:0] div_cycles(input logic [1:0] code);
        return (code == 2'b00) ? 3'd4 : {1'b0, code};
    endfunction

endpackage

// File: rtl/strobe_link_fifo.sv
module strobe_link_fifo #(
    parameter int DATA_W = 48,
    parameter int DEPTH  = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             rd;
        logic [PTR_W-1:0]             wr;
        logic [CNT_W-1:0]             cnt;
    } fifo_t;

    fifo_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign count = st_q.cnt;
    assign head  = st_q.mem[st_q.rd];

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (push && !full) begin
                st_d.mem[st_q.wr] = push_data;
                st_d.wr           = ptr_next(st_q.wr);
            end
            if (pop && !empty) begin
                st_d.rd = ptr_next(st_q.rd);
            end
            case ({push && !full, pop && !empty})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/strobe_link_phase_timer.sv
module strobe_link_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign done = (cnt_q == limit - 1'b1);

    always_comb begin
        cnt_d = clr ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/strobe_link_lane_sel.sv
module strobe_link_lane_sel #(
    parameter int WORD_W  = 48,
    parameter int SHORT_W = 32,
    parameter int LANE_W  = 8,
    parameter int IDX_W   = 4
) (
    input  logic [WORD_W-1:0] word,
    input  logic              wide,
    input  logic              byte_path,
    input  logic [IDX_W-1:0]  unit_idx,
    output logic [LANE_W-1:0] lane,
    output logic [IDX_W-1:0]  last_idx
);

    localparam int HALF_W   = LANE_W / 2;
    localparam int LONG_B   = WORD_W / LANE_W;
    localparam int LONG_N   = WORD_W / HALF_W;
    localparam int SHORT_B  = SHORT_W / LANE_W;
    localparam int SHORT_N  = SHORT_W / HALF_W;

    logic [IDX_W-1:0]  rem;
    logic [WORD_W-1:0] shifted;
    int                shift_amt;

    always_comb begin
        case ({wide, byte_path})
            2'b11:   last_idx = IDX_W'(LONG_B - 1);
            2'b10:   last_idx = IDX_W'(LONG_N - 1);
            2'b01:   last_idx = IDX_W'(SHORT_B - 1);
            default: last_idx = IDX_W'(SHORT_N - 1);
        endcase
        rem       = last_idx - unit_idx;
        shift_amt = byte_path ? int'(rem) * LANE_W : int'(rem) * HALF_W;
        shifted   = word >> shift_amt;
        if (byte_path) begin
            lane = shifted[LANE_W-1:0];
        end else begin
            lane = {{(LANE_W - HALF_W){1'b0}}, shifted[HALF_W-1:0]};
        end
    end

endmodule

// File: rtl/strobe_link_tx.sv
module strobe_link_tx
    import strobe_link_pkg::*;
#(
    parameter int WORD_W  = 48,
    parameter int SHORT_W = 32,
    parameter int LANE_W  = 8,
    parameter int DEPTH   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wide_word,
    input  logic              byte_lane,
    input  logic [1:0]        clk_div,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              overflow,
    input  logic              ack_in,
    output logic [LANE_W-1:0] lnk_data,
    output logic              lnk_clk,
    output logic [1:0]        fifo_status
);

    localparam int MAX_UNITS = WORD_W / (LANE_W / 2);
    localparam int IDX_W     = $clog2(MAX_UNITS);
    localparam int CNT_W     = $clog2(DEPTH + 1);
    localparam int TMR_W     = 3;

    typedef struct packed {
        tx_state_e        st;
        logic [IDX_W-1:0] unit;
        logic             wide;
        logic             byte_path;
        logic [1:0]       div;
        logic             en;
        logic             ovf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [WORD_W-1:0] head_word;
    logic [CNT_W-1:0]  fifo_count;
    logic              fifo_full;
    logic              fifo_empty;
    logic              pop_word;
    logic              tmr_clr;
    logic              tmr_done;
    logic [LANE_W-1:0] lane_val;
    logic [IDX_W-1:0]  last_idx;
    logic              stall_w;

    assign wr_ready = enable && ctl_q.en && !fifo_full;

    strobe_link_fifo #(
        .DATA_W (WORD_W),
        .DEPTH  (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!enable),
        .push      (wr_valid && wr_ready),
        .push_data (wr_data),
        .pop       (pop_word),
        .head      (head_word),
        .count     (fifo_count),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    strobe_link_phase_timer #(
        .CNT_W (TMR_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .limit (div_cycles(ctl_q.div)),
        .done  (tmr_done)
    );

    strobe_link_lane_sel #(
        .WORD_W  (WORD_W),
        .SHORT_W (SHORT_W),
        .LANE_W  (LANE_W),
        .IDX_W   (IDX_W)
    ) u_lane (
        .word      (head_word),
        .wide      (ctl_q.wide),
        .byte_path (ctl_q.byte_path),
        .unit_idx  (ctl_q.unit),
        .lane      (lane_val),
        .last_idx  (last_idx)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.en  = enable;
        ctl_d.ovf = wr_valid && !wr_ready;
        pop_word  = 1'b0;
        tmr_clr   = 1'b0;

        // Settings are taken only on the enable edge.
        if (enable && !ctl_q.en) begin
            ctl_d.wide      = wide_word;
            ctl_d.byte_path = byte_lane;
            ctl_d.div       = clk_div;
        end

        if (!enable) begin
            ctl_d.st   = TX_IDLE;
            ctl_d.unit = '0;
            tmr_clr    = 1'b1;
        end else begin
            case (ctl_q.st)
                TX_IDLE: begin
                    tmr_clr = 1'b1;
                    if (!fifo_empty) begin
                        ctl_d.unit = '0;
                        ctl_d.st   = ack_in ? TX_HIGH : TX_STALL;
                    end
                end
                TX_STALL: begin
                    tmr_clr = 1'b1;
                    if (ack_in) begin
                        ctl_d.st = TX_LOW;
                    end
                end
                TX_HIGH: begin
                    if (tmr_done) begin
                        tmr_clr  = 1'b1;
                        ctl_d.st = TX_LOW;
                    end
                end
                TX_LOW: begin
                    if (tmr_done) begin
                        tmr_clr = 1'b1;
                        if (ctl_q.unit == last_idx) begin
                            // Word boundary: retire it and look at acknowledge.
                            pop_word   = 1'b1;
                            ctl_d.unit = '0;
                            if (fifo_count > CNT_W'(1)) begin
                                ctl_d.st = ack_in ? TX_HIGH : TX_STALL;
                            end else begin
                                ctl_d.st = TX_IDLE;
                            end
                        end else begin
                            ctl_d.unit = ctl_q.unit + 1'b1;
                            ctl_d.st   = TX_HIGH;
                        end
                    end
                end
                default: ctl_d.st = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: TX_IDLE, div: 2'b01, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign stall_w     = (ctl_q.st == TX_STALL);
    assign lnk_clk     = (ctl_q.st == TX_HIGH) || stall_w;
    assign lnk_data    = (ctl_q.st == TX_IDLE) ? '0 : lane_val;
    assign overflow    = ctl_q.ovf;
    assign fifo_status = fifo_empty ? 2'b00 : (fifo_full ? 2'b11 : 2'b10);

endmodule

// File: rtl/strobe_link_tx_chk.sv
module strobe_link_tx_chk #(
    parameter int LANE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              overflow,
    input logic              ack_in,
    input logic [LANE_W-1:0] lnk_data,
    input logic              lnk_clk,
    input logic [1:0]        fifo_status,
    input logic              in_stall
);

    a_r6_empty_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_status == 2'b00) |-> (!lnk_clk && lnk_data == '0));

    a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stall && !ack_in && enable) |=> (lnk_clk && $stable(lnk_data)));

    a_r8_overflow_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> overflow);

    a_r8_no_spurious_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && !wr_ready) |=> !overflow);

    a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (fifo_status == 2'b00 && !lnk_clk));

    a_r7_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_status == 2'b11) |-> !wr_ready);

    always @(posedge clk) begin
        if (rst_n) begin
            a_r7_status_code: assert (fifo_status != 2'b01);
        end
    end

endmodule

bind strobe_link_tx strobe_link_tx_chk #(.LANE_W(LANE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .overflow    (overflow),
    .ack_in      (ack_in),
    .lnk_data    (lnk_data),
    .lnk_clk     (lnk_clk),
    .fifo_status (fifo_status),
    .in_stall    (stall_w)
);

// File: tb/strobe_link_tx_bench.sv
module strobe_link_tx_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        wide_word = 1'b0;
    logic        byte_lane = 1'b1;
    logic [1:0]  clk_div = 2'b01;
    logic        wr_valid = 1'b0;
    logic [47:0] wr_data = '0;
    logic        wr_ready;
    logic        overflow;
    logic        ack_in = 1'b0;
    logic [7:0]  lnk_data;
    logic        lnk_clk;
    logic [1:0]  fifo_status;

    int checks = 0;
    int failures = 0;
    int fall_count = 0;
    bit mute = 1'b1;
    bit prev_clk = 1'b0;
    bit lat_wide = 1'b0;
    bit lat_byte = 1'b1;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    strobe_link_tx u_strobe_link_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .wide_word   (wide_word),
        .byte_lane   (byte_lane),
        .clk_div     (clk_div),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .wr_ready    (wr_ready),
        .overflow    (overflow),
        .ack_in      (ack_in),
        .lnk_data    (lnk_data),
        .lnk_clk     (lnk_clk),
        .fifo_status (fifo_status)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int div_n(input logic [1:0] code);
        return (code == 2'b00) ? 4 : int'(code);
    endfunction

    // Scoreboard driver side: expected parts, most significant first (R1, R2).
    task automatic push_expected(input logic [47:0] w);
        int tot = lat_wide ? 48 : 32;
        int ln  = lat_byte ? 8 : 4;
        for (int u = 0; u < tot / ln; u++) begin
            exp_q.push_back(8'((w >> (tot - ln * (u + 1))) & 48'((1 << ln) - 1)));
        end
    endtask

    // Monitor: every strobe fall delivers one part.
    always @(negedge clk) begin
        if (rst_n && !mute && prev_clk && !lnk_clk) begin
            fall_count++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected part", longint'(lnk_data), 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(lnk_data == e, "R1/R2 part value", longint'(lnk_data), longint'(e));
            end
        end
        prev_clk = lnk_clk;
    end

    task automatic reconfig(input bit w, input bit b, input logic [1:0] d);
        @(negedge clk);
        mute   = 1'b1;
        enable = 1'b0;
        repeat (2) @(negedge clk);
        wide_word = w;
        byte_lane = b;
        clk_div   = d;
        enable    = 1'b1;
        lat_wide  = w;
        lat_byte  = b;
        repeat (2) @(negedge clk);
        mute = 1'b0;
    endtask

    task automatic do_write(input logic [47:0] w, input bit expect_accept);
        @(negedge clk);
        check(wr_ready == expect_accept, "R7 wr_ready", longint'(wr_ready), longint'(expect_accept));
        wr_valid = 1'b1;
        wr_data  = w;
        if (expect_accept) push_expected(w);
        @(negedge clk);
        wr_valid = 1'b0;
        check(overflow == !expect_accept, "R8 overflow", longint'(overflow), longint'(!expect_accept));
    endtask

    task automatic wait_falls(input int target);
        while (fall_count < target) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int base;
        int hi;
        int lo;
        bit ok;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(lnk_clk == 1'b0, "R6 reset clk", longint'(lnk_clk), 0);
        check(lnk_data == 8'h00, "R6 reset data", longint'(lnk_data), 0);
        check(fifo_status == 2'b00, "R7 reset status", longint'(fifo_status), 0);
        check(wr_ready == 1'b0, "R7 ready while disabled", longint'(wr_ready), 0);
        check(overflow == 1'b0, "R8 reset overflow", longint'(overflow), 0);

        // R6: empty queue keeps the strobe low even with acknowledge high.
        reconfig(1'b0, 1'b1, 2'b01);
        ack_in = 1'b1;
        ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (lnk_clk || lnk_data != 0) ok = 1'b0;
        end
        check(ok, "R6 idle strobe low", longint'(lnk_clk), 0);

        // R3: every divisor code, high and low time of one part.
        for (int c = 0; c < 4; c++) begin
            reconfig(1'b0, 1'b1, 2'(c));
            ack_in = 1'b1;
            base = fall_count;
            do_write(48'h0000_A1B2_C3D4, 1'b1);
            while (!lnk_clk) @(negedge clk);
            hi = 0;
            while (lnk_clk) begin hi++; @(negedge clk); end
            lo = 0;
            while (!lnk_clk) begin lo++; @(negedge clk); end
            check(hi == div_n(2'(c)), "R3 high time", longint'(hi), longint'(div_n(2'(c))));
            check(lo == div_n(2'(c)), "R3 low time", longint'(lo), longint'(div_n(2'(c))));
            wait_falls(base + 4);
            repeat (6) @(negedge clk);
            check(fifo_status == 2'b00, "R7 drained", longint'(fifo_status), 0);
        end

        // R1: nibble lane, both word sizes.
        reconfig(1'b0, 1'b0, 2'b01);
        base = fall_count;
        do_write(48'h0000_9876_5432, 1'b1);
        wait_falls(base + 8);
        repeat (4) @(negedge clk);
        check(fall_count == base + 8, "R1 short nibble count", longint'(fall_count - base), 8);
        reconfig(1'b1, 1'b0, 2'b10);
        base = fall_count;
        do_write(48'hFEDC_BA98_7654, 1'b1);
        wait_falls(base + 12);
        repeat (6) @(negedge clk);
        check(fall_count == base + 12, "R1 long nibble count", longint'(fall_count - base), 12);

        // R5, R7, R8: stall with a full queue.
        reconfig(1'b1, 1'b1, 2'b11);
        ack_in = 1'b0;
        base = fall_count;
        do_write(48'h1122_3344_5566, 1'b1);
        @(negedge clk);
        check(fifo_status == 2'b10, "R7 one word", longint'(fifo_status), 2);
        do_write(48'h7788_99AA_BBCC, 1'b1);
        check(fifo_status == 2'b11, "R7 full", longint'(fifo_status), 3);
        repeat (5) @(negedge clk);
        check(lnk_clk == 1'b1, "R5 stall strobe high", longint'(lnk_clk), 1);
        check(lnk_data == 8'h11, "R5 stall first byte", longint'(lnk_data), 8'h11);
        do_write(48'hDEAD_DEAD_DEAD, 1'b0);
        @(negedge clk);
        check(overflow == 1'b0, "R8 pulse one cycle", longint'(overflow), 0);
        check(lnk_clk == 1'b1 && lnk_data == 8'h11 && fall_count == base,
              "R5 still stalled", longint'(lnk_data), 8'h11);
        ack_in = 1'b1;
        @(negedge clk);
        check(lnk_clk == 1'b0, "R5 strobe falls after ack", longint'(lnk_clk), 0);
        wait_falls(base + 12);
        repeat (8) @(negedge clk);
        check(fifo_status == 2'b00, "R9 both words sent", longint'(fifo_status), 0);

        // R4: acknowledge drops mid-word; the word completes, the next stalls.
        reconfig(1'b1, 1'b1, 2'b10);
        ack_in = 1'b1;
        base = fall_count;
        do_write(48'h0102_0304_0506, 1'b1);
        do_write(48'hA0B0_C0D0_E0F0, 1'b1);
        wait_falls(base + 1);
        ack_in = 1'b0;
        wait_falls(base + 6);
        repeat (3) @(negedge clk);
        check(lnk_clk == 1'b1 && lnk_data == 8'hA0, "R4 next word stalls", longint'(lnk_data), 8'hA0);
        check(fifo_status == 2'b10, "R4 first word retired", longint'(fifo_status), 2);
        repeat (10) @(negedge clk);
        check(fall_count == base + 6, "R4 held while ack low", longint'(fall_count - base), 6);
        ack_in = 1'b1;
        wait_falls(base + 12);
        repeat (6) @(negedge clk);

        // R11: settings changed while enabled are ignored.
        reconfig(1'b0, 1'b1, 2'b01);
        wide_word = 1'b1;
        byte_lane = 1'b0;
        clk_div   = 2'b00;
        base = fall_count;
        do_write(48'h5555_CAFE_F00D, 1'b1);
        while (!lnk_clk) @(negedge clk);
        hi = 0;
        while (lnk_clk) begin hi++; @(negedge clk); end
        check(hi == 1, "R11 divisor kept", longint'(hi), 1);
        wait_falls(base + 4);
        repeat (10) @(negedge clk);
        check(fall_count == base + 4, "R11 word size kept", longint'(fall_count - base), 4);

        // R10: disabling discards queued words.
        reconfig(1'b1, 1'b1, 2'b01);
        ack_in = 1'b0;
        do_write(48'h0F0F_0F0F_0F0F, 1'b1);
        do_write(48'hF0F0_F0F0_F0F0, 1'b1);
        repeat (3) @(negedge clk);
        mute   = 1'b1;
        enable = 1'b0;
        @(negedge clk);
        check(fifo_status == 2'b00 && lnk_clk == 1'b0, "R10 cleared", longint'(fifo_status), 0);
        exp_q.delete();
        ack_in = 1'b1;
        enable = 1'b1;
        repeat (2) @(negedge clk);
        mute = 1'b0;
        base = fall_count;
        repeat (40) @(negedge clk);
        check(fall_count == base, "R10 discarded words not sent", longint'(fall_count - base), 0);
        check(exp_q.size() == 0, "R9 scoreboard empty", longint'(exp_q.size()), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule